// File: doc/BRIEF.md
# Hsync Coast Gating Controller

This block tells a line-locked clock generator when to stop following horizontal sync and hold its present frequency. Two sources can request this hold. The first is an external coast input, which is interpreted as active-high or active-low. The polarity comes from a user bit when the force bit is set, and from an automatic detector otherwise. The second is an internal coast that covers the vertical sync pulse. It can also start a programmable number of lines before vertical sync, so that pre-equalization pulses never reach the clock generator. The start line is predicted from the length of the previous frame, counted in hsync periods.

The block outputs a registered active-high ignore qualifier and a gated copy of hsync. The gated copy is forced low while the qualifier is set. Every input, including the configuration pins, passes through a two-flop synchronizer. Hsync and vsync are taken as active-high, and their rising edges become one-cycle pulses. The sync inputs and outputs are plain timing levels, not data transfers. They carry no valid/ready handshake and cannot be back-pressured. A downstream stage that misses a gated pulse loses it.

Top module: `coast_gate_ctrl`

## Requirements
- R1: After reset, `hs_ignore` and `hsync_gated` are low. The automatic polarity is active-high, and no frame length is stored, so no early coast is predicted.
- R2: With `coast_pol_force` = 1, `coast_pol_user` sets the external coast polarity (1 = active-high, 0 = active-low), and the automatic decision has no effect.
- R3: When the polarity in effect is active-high, `hs_ignore` is set while `coast_in` is high. When it is active-low, `hs_ignore` is set while `coast_in` is low.
- R4: With `coast_pol_force` = 0, the block counts hsync rising edges seen with `coast_in` high and with `coast_in` low, from one vsync rising edge to the next. At each vsync rising edge the less frequent level becomes active: fewer high lines gives active-high, fewer low lines gives active-low. A tie keeps the previous decision. Both counts then restart.
- R5: While the synchronized vsync is high, `hs_ignore` is set regardless of the other inputs.
- R6: The line counter counts hsync rising edges since the last vsync rising edge. That edge stores the count as the frame length and clears the counter. With `precoast_lines` P > 0 and a stored length L, the internal coast is set once the counter reaches L − P (or 0 if P ≥ L). It stays set until vsync falls.
- R7: With `precoast_lines` = 0 the internal coast covers only the vsync pulse.
- R8: The line counter and the polarity counts saturate at 4095. A stored frame length of 4095 or of 0 is invalid, and the next frame then gets no early coast.
- R9: `hsync_gated` follows the synchronized hsync while no coast is in effect and is low while any coast is in effect. It is never high in a cycle where `hs_ignore` is high. Both outputs are registered and follow a level input within four clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coast_in | input | 1 | External coast request, polarity per R2/R4 |
| coast_pol_user | input | 1 | User polarity: 1 active-high, 0 active-low |
| coast_pol_force | input | 1 | 1 = use user polarity, 0 = automatic |
| vsync_in | input | 1 | Extracted vertical sync, active-high |
| hsync_in | input | 1 | Horizontal sync pulses, active-high |
| precoast_lines | input | 8 | Lines of coast ahead of vsync, 0 = none |
| hs_ignore | output | 1 | Active-high hold request to the clock generator |
| hsync_gated | output | 1 | Hsync with pulses removed during coast |

## Verification
Several rules are checked on every clock cycle. Hsync and vsync edge pulses last one cycle, and the line counter clears after each vsync edge and holds once saturated. A saturated count invalidates the prediction, and the automatic polarity changes only at a vsync edge. The gated hsync never overlaps the ignore flag, and vsync always raises it. Other behaviour only shows across whole frames of scenarios. This covers the line on which the predicted coast begins, the polarity picked from a frame's coast pattern (including the tie case), and the hand-over between forced and automatic polarity. It also covers the loss of prediction after an over-long frame and its return one frame later.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int CG_LINE_W = 12;
  localparam int CG_PC_W   = 8;

  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } cpol_e;
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cg_edge.sv
module cg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;

  // R6: an edge pulse lasts exactly one cycle
  a_r6_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/cg_poldet.sv
module cg_poldet
  import cg_pkg::*;
#(
  parameter int LINE_W = CG_LINE_W
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  coast_lvl,
  input  logic  hs_rise,
  input  logic  vs_rise,
  output cpol_e pol_auto
);
  localparam logic [LINE_W-1:0] CNT_MAX = '1;

  logic [LINE_W-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      pol_auto <= POL_HIGH;
    end else if (vs_rise) begin
      if (hi_cnt < lo_cnt)      pol_auto <= POL_HIGH;
      else if (hi_cnt > lo_cnt) pol_auto <= POL_LOW;
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (hs_rise) begin
      if (coast_lvl && hi_cnt != CNT_MAX)  hi_cnt <= hi_cnt + 1'b1;
      if (!coast_lvl && lo_cnt != CNT_MAX) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  // R4: the decision moves only at a vsync leading edge
  a_r4_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> $stable(pol_auto));
endmodule

// File: rtl/cg_precoast.sv
module cg_precoast
  import cg_pkg::*;
#(
  parameter int LINE_W = CG_LINE_W,
  parameter int PC_W   = CG_PC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hs_rise,
  input  logic            vs_rise,
  input  logic            vs_lvl,
  input  logic [PC_W-1:0] pre_lines,
  output logic            coast_int
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] line_cnt, frame_len, pre_ext, start_line;
  logic              len_ok, pre_hit;

  assign pre_ext    = LINE_W'(pre_lines);
  assign start_line = (pre_ext >= frame_len) ? '0 : frame_len - pre_ext;
  assign pre_hit    = len_ok && (pre_lines != '0) && (line_cnt >= start_line);
  assign coast_int  = vs_lvl | pre_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt  <= '0;
      frame_len <= '0;
      len_ok    <= 1'b0;
    end else if (vs_rise) begin
      frame_len <= line_cnt;
      len_ok    <= (line_cnt != LINE_MAX) && (line_cnt != '0);
      line_cnt  <= '0;
    end else if (hs_rise && line_cnt != LINE_MAX) begin
      line_cnt <= line_cnt + 1'b1;
    end
  end

  // R6: a vsync leading edge restarts the line count
  a_r6_clear_on_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (line_cnt == '0));
  // R8: a saturated count stays put until vsync
  a_r8_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cnt == LINE_MAX && !vs_rise) |=> (line_cnt == LINE_MAX));
  // R8: a saturated frame yields no prediction
  a_r8_no_pred_after_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && line_cnt == LINE_MAX) |=> !len_ok);
endmodule

// File: rtl/coast_gate_ctrl.sv
module coast_gate_ctrl
  import cg_pkg::*;
#(
  parameter int LINE_W = CG_LINE_W,
  parameter int PC_W   = CG_PC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            coast_in,
  input  logic            coast_pol_user,
  input  logic            coast_pol_force,
  input  logic            vsync_in,
  input  logic            hsync_in,
  input  logic [PC_W-1:0] precoast_lines,
  output logic            hs_ignore,
  output logic            hsync_gated
);
  localparam int SYNC_W = 5 + PC_W;

  logic [SYNC_W-1:0] raw_bus, sync_bus;
  logic              coast_s, usr_s, frc_s, vs_s, hs_s;
  logic [PC_W-1:0]   pc_s;
  logic              hs_rise, vs_rise, coast_int, ext_act, ignore_c;
  cpol_e             pol_auto, pol_eff;

  assign raw_bus = {coast_in, coast_pol_user, coast_pol_force, vsync_in, hsync_in, precoast_lines};

  cg_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus));

  assign {coast_s, usr_s, frc_s, vs_s, hs_s, pc_s} = sync_bus;

  cg_edge u_hs_edge (.clk(clk), .rst_n(rst_n), .lvl(hs_s), .rise(hs_rise));
  cg_edge u_vs_edge (.clk(clk), .rst_n(rst_n), .lvl(vs_s), .rise(vs_rise));

  cg_poldet #(.LINE_W(LINE_W)) u_pol (
    .clk(clk), .rst_n(rst_n), .coast_lvl(coast_s), .hs_rise(hs_rise),
    .vs_rise(vs_rise), .pol_auto(pol_auto));

  cg_precoast #(.LINE_W(LINE_W), .PC_W(PC_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .vs_rise(vs_rise),
    .vs_lvl(vs_s), .pre_lines(pc_s), .coast_int(coast_int));

  assign pol_eff  = frc_s ? cpol_e'(usr_s) : pol_auto;
  assign ext_act  = (pol_eff == POL_HIGH) ? coast_s : ~coast_s;
  assign ignore_c = ext_act | coast_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_ignore   <= 1'b0;
      hsync_gated <= 1'b0;
    end else begin
      hs_ignore   <= ignore_c;
      hsync_gated <= hs_s & ~ignore_c;
    end
  end

  // R9: gated hsync and the hold request never overlap
  a_r9_gate_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_gated |-> !hs_ignore);
  // R5: vsync always forces the hold request
  a_r5_vsync_holds: assert property (@(posedge clk) disable iff (!rst_n)
    vs_s |=> hs_ignore);
endmodule

// File: tb/sim_coast_gate_ctrl.sv
module sim_coast_gate_ctrl;
  localparam int LMAX = 4095;
  localparam int LINE_CYC = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic coast_in = 1'b0, pol_user = 1'b0, pol_force = 1'b0;
  logic vsync_in = 1'b0, hsync_in = 1'b0;
  logic [7:0] pc = 8'd0;
  logic hs_ignore, hsync_gated;

  always #5 clk = ~clk;

  coast_gate_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .coast_in(coast_in), .coast_pol_user(pol_user),
    .coast_pol_force(pol_force), .vsync_in(vsync_in), .hsync_in(hsync_in),
    .precoast_lines(pc), .hs_ignore(hs_ignore), .hsync_gated(hsync_gated));

  int n_chk = 0, n_fail = 0;
  int cnt_m = 0, len_m = 0, hi_m = 0, lo_m = 0;
  bit ok_m = 0, pol_m = 1, vs_m = 0, coast_m = 0;
  int N = 20, P = 0, VSL = 2, cs = 0, ce = 0;
  string scen = "reset";

  function automatic bit pre_m();
    int tgt;
    tgt = (P >= len_m) ? 0 : len_m - P;
    return ok_m && (P != 0) && (cnt_m >= tgt);
  endfunction

  function automatic bit exp_ign();
    bit pe;
    pe = pol_force ? pol_user : pol_m;
    return (pe ? coast_m : !coast_m) | vs_m | pre_m();
  endfunction

  function automatic string cause();
    if (vs_m)     return "R5";
    if (pre_m())  return "R6";
    if (pol_force) return "R2 R3";
    return "R4 R3";
  endfunction

  task automatic chk(string tag, logic act, logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s [%s]: got %b expected %b", tag, scen, act, expv);
    end
  endtask

  task automatic run_frame();
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < LINE_CYC; c++) begin
        @(negedge clk);
        if (c == 5) begin
          chk(cause(), hs_ignore, exp_ign());
          chk("R9 pass", hsync_gated, !exp_ign());
        end
        if (c == 14) begin
          chk(cause(), hs_ignore, exp_ign());
          chk("R9 idle", hsync_gated, 1'b0);
        end
        hsync_in = (c < 4);
        if (c == 0) begin
          if (cnt_m < LMAX) cnt_m++;
          if (coast_m) begin if (hi_m < LMAX) hi_m++; end
          else begin if (lo_m < LMAX) lo_m++; end
        end
        if (c == 8) begin
          if (i == 0) begin
            vsync_in = 1'b1; vs_m = 1;
            len_m = cnt_m;
            ok_m  = (cnt_m != 0) && (cnt_m != LMAX);
            cnt_m = 0;
            if (hi_m < lo_m) pol_m = 1;
            else if (hi_m > lo_m) pol_m = 0;
            hi_m = 0; lo_m = 0;
          end
          if (i == VSL) begin vsync_in = 1'b0; vs_m = 0; end
          coast_in = (i >= cs && i < ce);
          coast_m  = coast_in;
        end
      end
    end
  endtask

  task automatic scenario(string s, int n, int p, int vsl, int a, int b,
                          bit f, bit u, int frames);
    @(negedge clk);
    scen = s; N = n; P = p; VSL = vsl; cs = a; ce = b;
    pol_force = f; pol_user = u; pc = 8'(p);
    for (int k = 0; k < frames; k++) run_frame();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h00C0A57);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 ignore", hs_ignore, 1'b0);
    chk("R1 gated", hsync_gated, 1'b0);

    scenario("R3 R4 sparse high coast", 30, 0, 3, 2, 6, 0, 0, 3);
    scenario("R3 R4 mostly high coast", 30, 0, 3, 0, 25, 0, 0, 3);
    scenario("R4 tie keeps polarity", 20, 0, 2, 0, 10, 0, 0, 3);
    scenario("R2 forced high", 24, 0, 2, 4, 9, 1, 1, 2);
    scenario("R2 forced low", 24, 0, 2, 4, 9, 1, 0, 2);
    scenario("R7 zero precoast", 28, 0, 3, 0, 0, 0, 0, 2);
    scenario("R6 precoast five", 28, 5, 3, 0, 0, 0, 0, 3);
    scenario("R6 precoast beyond frame", 20, 255, 2, 0, 0, 0, 0, 2);
    scenario("R8 saturating frame", 4100, 6, 2, 0, 0, 0, 0, 1);
    scenario("R8 after saturation", 40, 6, 2, 0, 0, 0, 0, 3);
    for (int r = 0; r < 6; r++) begin
      int n, p, a;
      n = 20 + int'($urandom_range(0, 40));
      p = int'($urandom_range(0, n + 4));
      a = int'($urandom_range(0, n - 1));
      scenario("R6 random", n, p, 1 + int'($urandom_range(0, 3)), a,
               a + int'($urandom_range(0, n)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 3);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule